// File: doc/BRIEF.md
# Processor Address Router

This block decides where each processor request goes inside a host bridge. Every cycle it may accept one request, made of an address, a read/write flag, a flag marking an interrupt-type transaction and a valid bit. One clock later it presents a registered one-hot destination: coherent main memory, non-coherent main memory, configuration-space conversion, the legacy downstream port, master-abort through the legacy port, the processor bus, or one of the PCIe ports.

The decode is steered by software-programmed values that arrive here as plain input ports. These are the top of low memory, the high-memory limit, the configuration region base, and a two-bit shadow attribute for each segment of the BIOS area (0xC0000 to 0xFFFFF). Each PCIe port also has a memory window, a prefetchable window and a memory-enable bit. Rules are tested in a fixed priority. The fixed low ranges come first, then the configuration region, then the fixed high ranges and high memory, then the port windows. Anything left over goes to the legacy port by subtractive decode.

Top module: `addr_router`

## Requirements
- R1: `destValid` rises exactly one clock after a cycle with `reqValid` high. In that cycle exactly one bit of `destOh` is set. In any cycle where `destValid` is low, `destOh` is all zero, and reset clears both. Bit positions are: 0 coherent memory, 1 non-coherent memory, 2 configuration, 3 legacy port, 4 master-abort, 5 processor bus, and 6+p for PCIe port p.
- R2: Addresses 0x0 through 0x9FFFF go to coherent memory.
- R3: The BIOS area 0xC0000 to 0xFFFFF is split into `SHADOW_SEGS` equal segments. Segment k takes its attribute from `shadowAttr[2k+1:2k]`. Attribute bit 0 sends reads to non-coherent memory, and attribute bit 1 does the same for writes. A clear bit sends that direction to the legacy port.
- R4: An address with 0x100000 <= a < `topLowMem` goes to coherent memory.
- R5: An address with `cfgBase` <= a < `cfgBase` + 2^`CFG_SIZE_LOG2` goes to configuration. This rule ranks below R2, R3 and R4 and above every port window.
- R6: The range 0xFEE00000 to 0xFEEFFFFF goes to the processor bus when `reqIsIntr` is set, and to master-abort otherwise. Interrupt-type requests outside this range decode by address like any other request.
- R7: The ranges 0xFEC90000 to 0xFED1FFFF and 0xFF000000 to 0xFFFFFFFF go to the legacy port.
- R8: An address with 4 GB <= a < `highMemLimit` goes to coherent memory.
- R9: Port p's memory window applies only when `topLowMem` <= a < 0xFE000000 and the upper address bits above bit 31 are zero. It claims the address when the low 32 bits satisfy base <= a <= limit and `portMemEn[p]` is set. If several windows hit, the lowest port index wins.
- R10: In the gap `topLowMem` <= a < 0xFE000000, an address that no higher rule or window claims goes to master-abort. No address from the gap up to 4 GB reaches main memory.
- R11: Port p's prefetchable window is {hi, lo} base <= a <= {hi, lo} limit, where hi is the port's slice of `portPfBaseHi`/`portPfLimitHi`. It claims the address only while `portMemEn[p]` is set.
- R12: Any address no rule claims, for example 0xA0000, 0xFE000000 or an address at or above `highMemLimit` outside every window, goes to the legacy port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIsIntr | input | 1 | 1 = interrupt-type transaction |
| topLowMem | input | ADDR_W | Top of low memory (exclusive) |
| highMemLimit | input | ADDR_W | Top of high memory (exclusive) |
| cfgBase | input | ADDR_W | Base of the configuration region |
| shadowAttr | input | 2*SHADOW_SEGS | Per-segment read/write steering bits |
| portMemEn | input | NUM_PORTS | Per-port memory-enable |
| portMemBase | input | 32*NUM_PORTS | Per-port memory window base |
| portMemLimit | input | 32*NUM_PORTS | Per-port memory window limit (inclusive) |
| portPfBaseLo | input | 32*NUM_PORTS | Prefetchable base, low 32 bits |
| portPfBaseHi | input | (ADDR_W-32)*NUM_PORTS | Prefetchable base, upper bits |
| portPfLimitLo | input | 32*NUM_PORTS | Prefetchable limit, low 32 bits |
| portPfLimitHi | input | (ADDR_W-32)*NUM_PORTS | Prefetchable limit, upper bits |
| destValid | output | 1 | Destination valid |
| destOh | output | 6+NUM_PORTS | One-hot destination |

## Verification
Every routing result is due at the first rising edge after the request is sampled, so it is visible one clock after `reqValid` is driven. The bench applies each request at a falling edge and reads `destValid` and `destOh` at the next falling edge, half a period after the register updates. Programmed values are changed only while no request is in flight, so each check reflects a single known configuration. The idle check drops `reqValid` and reads the outputs at the same one-clock offset.

// File: rtl/addr_router_pkg.sv
`timescale 1ns/1ps
package addr_router_pkg;
  // one-hot destination bit positions
  localparam int DEST_COH    = 0;
  localparam int DEST_NCOH   = 1;
  localparam int DEST_CFG    = 2;
  localparam int DEST_LEGACY = 3;
  localparam int DEST_ABORT  = 4;
  localparam int DEST_CPUBUS = 5;
  localparam int DEST_PORT0  = 6;

  // range strobes from the compare datapath to the priority control
  typedef struct packed {
    logic dosHit;
    logic shadowHit;
    logic shadowToMem;
    logic lowMemHit;
    logic cfgHit;
    logic intrRangeHit;
    logic fixedLegacyHit;
    logic highMemHit;
    logic gapHit;
  } hitT;
endpackage

// File: rtl/addr_router_cmp.sv
`timescale 1ns/1ps
module addr_router_cmp
  import addr_router_pkg::*;
#(
  parameter int ADDR_W        = 36,
  parameter int NUM_PORTS     = 6,
  parameter int SHADOW_SEGS   = 4,
  parameter int CFG_SIZE_LOG2 = 28
) (
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             topLowMem,
  input  logic [ADDR_W-1:0]             highMemLimit,
  input  logic [ADDR_W-1:0]             cfgBase,
  input  logic [2*SHADOW_SEGS-1:0]      shadowAttr,
  input  logic [NUM_PORTS-1:0]          portMemEn,
  input  logic [32*NUM_PORTS-1:0]       portMemBase,
  input  logic [32*NUM_PORTS-1:0]       portMemLimit,
  input  logic [32*NUM_PORTS-1:0]       portPfBaseLo,
  input  logic [(ADDR_W-32)*NUM_PORTS-1:0] portPfBaseHi,
  input  logic [32*NUM_PORTS-1:0]       portPfLimitLo,
  input  logic [(ADDR_W-32)*NUM_PORTS-1:0] portPfLimitHi,
  output hitT                           hits,
  output logic [NUM_PORTS-1:0]          portHit
);
  localparam int HI_W   = ADDR_W - 32;
  localparam int SEG_IW = $clog2(SHADOW_SEGS);
  localparam int SEG_SH = 18 - SEG_IW;

  localparam logic [ADDR_W-1:0] DOS_END     = ADDR_W'(64'h0000_A0000);
  localparam logic [ADDR_W-1:0] BIOS_START  = ADDR_W'(64'h0000_C0000);
  localparam logic [ADDR_W-1:0] ONE_MEG     = ADDR_W'(64'h0010_0000);
  localparam logic [ADDR_W-1:0] GAP_END     = ADDR_W'(64'hFE00_0000);
  localparam logic [ADDR_W-1:0] INTR_LO     = ADDR_W'(64'hFEE0_0000);
  localparam logic [ADDR_W-1:0] INTR_HI     = ADDR_W'(64'hFEEF_FFFF);
  localparam logic [ADDR_W-1:0] LEGA_LO     = ADDR_W'(64'hFEC9_0000);
  localparam logic [ADDR_W-1:0] LEGA_HI     = ADDR_W'(64'hFED1_FFFF);
  localparam logic [ADDR_W-1:0] FW_LO       = ADDR_W'(64'hFF00_0000);
  localparam logic [ADDR_W-1:0] FOUR_GIG    = ADDR_W'(64'h1_0000_0000);
  localparam logic [ADDR_W:0]   CFG_SPAN    = (ADDR_W+1)'(1) << CFG_SIZE_LOG2;

  logic [SEG_IW-1:0] segIdx;
  logic [1:0]        segAttr;
  logic [ADDR_W:0]   cfgEnd;

  assign segIdx  = reqAddr[17:SEG_SH];
  assign segAttr = shadowAttr[{segIdx, 1'b0} +: 2];
  assign cfgEnd  = {1'b0, cfgBase} + CFG_SPAN;

  assign hits.dosHit         = reqAddr < DOS_END;
  assign hits.shadowHit      = (reqAddr >= BIOS_START) && (reqAddr < ONE_MEG);
  assign hits.shadowToMem    = reqWrite ? segAttr[1] : segAttr[0];
  assign hits.lowMemHit      = (reqAddr >= ONE_MEG) && (reqAddr < topLowMem);
  assign hits.cfgHit         = (reqAddr >= cfgBase) && ({1'b0, reqAddr} < cfgEnd);
  assign hits.intrRangeHit   = (reqAddr >= INTR_LO) && (reqAddr <= INTR_HI);
  assign hits.fixedLegacyHit = ((reqAddr >= LEGA_LO) && (reqAddr <= LEGA_HI)) ||
                               ((reqAddr >= FW_LO) && (reqAddr < FOUR_GIG));
  assign hits.highMemHit     = (reqAddr >= FOUR_GIG) && (reqAddr < highMemLimit);
  assign hits.gapHit         = (reqAddr >= topLowMem) && (reqAddr < GAP_END);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [ADDR_W-1:0] pfBase;
    logic [ADDR_W-1:0] pfLimit;
    logic              memWinHit;
    logic              pfWinHit;
    assign pfBase    = {portPfBaseHi[p*HI_W +: HI_W], portPfBaseLo[p*32 +: 32]};
    assign pfLimit   = {portPfLimitHi[p*HI_W +: HI_W], portPfLimitLo[p*32 +: 32]};
    assign memWinHit = hits.gapHit && (reqAddr[ADDR_W-1:32] == '0) &&
                       (reqAddr[31:0] >= portMemBase[p*32 +: 32]) &&
                       (reqAddr[31:0] <= portMemLimit[p*32 +: 32]);
    assign pfWinHit  = (reqAddr >= pfBase) && (reqAddr <= pfLimit);
    assign portHit[p] = portMemEn[p] && (memWinHit || pfWinHit);
  end
endmodule

// File: rtl/addr_router_ctl.sv
`timescale 1ns/1ps
module addr_router_ctl
  import addr_router_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  localparam int DEST_W   = DEST_PORT0 + NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsIntr,
  input  hitT                  hits,
  input  logic [NUM_PORTS-1:0] portHit,
  output logic                 destValid,
  output logic [DEST_W-1:0]    destOh
);
  logic [DEST_W-1:0] nextDest;
  logic              portFound;

  always_comb begin
    nextDest  = '0;
    portFound = 1'b0;
    if (hits.dosHit)              nextDest[DEST_COH]    = 1'b1;
    else if (hits.shadowHit)      nextDest[hits.shadowToMem ? DEST_NCOH : DEST_LEGACY] = 1'b1;
    else if (hits.lowMemHit)      nextDest[DEST_COH]    = 1'b1;
    else if (hits.cfgHit)         nextDest[DEST_CFG]    = 1'b1;
    else if (hits.intrRangeHit)   nextDest[reqIsIntr ? DEST_CPUBUS : DEST_ABORT] = 1'b1;
    else if (hits.fixedLegacyHit) nextDest[DEST_LEGACY] = 1'b1;
    else if (hits.highMemHit)     nextDest[DEST_COH]    = 1'b1;
    else if (|portHit) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (portHit[p] && !portFound) begin
          nextDest[DEST_PORT0 + p] = 1'b1;
          portFound = 1'b1;
        end
      end
    end
    else if (hits.gapHit)         nextDest[DEST_ABORT]  = 1'b1;
    else                          nextDest[DEST_LEGACY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destValid <= 1'b0;
      destOh    <= '0;
    end else begin
      destValid <= reqValid;
      destOh    <= reqValid ? nextDest : '0;
    end
  end
endmodule

// File: rtl/addr_router.sv
`timescale 1ns/1ps
module addr_router
  import addr_router_pkg::*;
#(
  parameter int ADDR_W        = 36,
  parameter int NUM_PORTS     = 6,
  parameter int SHADOW_SEGS   = 4,
  parameter int CFG_SIZE_LOG2 = 28,
  localparam int HI_W         = ADDR_W - 32,
  localparam int DEST_W       = DEST_PORT0 + NUM_PORTS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          reqWrite,
  input  logic                          reqIsIntr,
  input  logic [ADDR_W-1:0]             topLowMem,
  input  logic [ADDR_W-1:0]             highMemLimit,
  input  logic [ADDR_W-1:0]             cfgBase,
  input  logic [2*SHADOW_SEGS-1:0]      shadowAttr,
  input  logic [NUM_PORTS-1:0]          portMemEn,
  input  logic [32*NUM_PORTS-1:0]       portMemBase,
  input  logic [32*NUM_PORTS-1:0]       portMemLimit,
  input  logic [32*NUM_PORTS-1:0]       portPfBaseLo,
  input  logic [HI_W*NUM_PORTS-1:0]     portPfBaseHi,
  input  logic [32*NUM_PORTS-1:0]       portPfLimitLo,
  input  logic [HI_W*NUM_PORTS-1:0]     portPfLimitHi,
  output logic                          destValid,
  output logic [DEST_W-1:0]             destOh
);
  hitT                  hits;
  logic [NUM_PORTS-1:0] portHit;

  addr_router_cmp #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS),
    .SHADOW_SEGS(SHADOW_SEGS), .CFG_SIZE_LOG2(CFG_SIZE_LOG2)
  ) u_cmp (
    .reqAddr(reqAddr), .reqWrite(reqWrite),
    .topLowMem(topLowMem), .highMemLimit(highMemLimit), .cfgBase(cfgBase),
    .shadowAttr(shadowAttr), .portMemEn(portMemEn),
    .portMemBase(portMemBase), .portMemLimit(portMemLimit),
    .portPfBaseLo(portPfBaseLo), .portPfBaseHi(portPfBaseHi),
    .portPfLimitLo(portPfLimitLo), .portPfLimitHi(portPfLimitHi),
    .hits(hits), .portHit(portHit)
  );

  addr_router_ctl #(.NUM_PORTS(NUM_PORTS)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsIntr(reqIsIntr),
    .hits(hits), .portHit(portHit),
    .destValid(destValid), .destOh(destOh)
  );
endmodule

// File: rtl/addr_router_chk.sv
`timescale 1ns/1ps
module addr_router_chk
  import addr_router_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DEST_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqIsIntr,
  input logic [ADDR_W-1:0] topLowMem,
  input logic              destValid,
  input logic [DEST_W-1:0] destOh
);
  localparam logic [ADDR_W-1:0] DOS_END  = ADDR_W'(64'h0000_A0000);
  localparam logic [ADDR_W-1:0] ONE_MEG  = ADDR_W'(64'h0010_0000);
  localparam logic [ADDR_W-1:0] FOUR_GIG = ADDR_W'(64'h1_0000_0000);

  // R1
  dest_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    destValid |-> $countones(destOh) == 1);

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !destValid |-> destOh == '0);

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> destValid);

  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !destValid);

  // R2
  dos_coherent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr < DOS_END) |=> destOh[DEST_COH]);

  // R10
  gap_no_memory_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= topLowMem && reqAddr >= ONE_MEG && reqAddr < FOUR_GIG)
      |=> !destOh[DEST_COH] && !destOh[DEST_NCOH]);

  // R6
  bus_only_interrupt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsIntr) |=> !destOh[DEST_CPUBUS]);
endmodule

bind addr_router addr_router_chk #(.ADDR_W(ADDR_W), .DEST_W(DEST_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqIsIntr(reqIsIntr), .topLowMem(topLowMem),
  .destValid(destValid), .destOh(destOh)
);

// File: tb/tb_addr_router.sv
`timescale 1ns/1ps
module tb_addr_router;
  localparam int AW = 36;
  localparam int NP = 6;
  localparam int NS = 4;
  localparam int HW = AW - 32;
  localparam int DW = 6 + NP;
  // destination bits as stated in R1
  localparam int COH = 0, NCOH = 1, CFG = 2, LEG = 3, ABT = 4, BUS = 5, P0 = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic reqIsIntr = 1'b0;
  logic [AW-1:0] topLowMem, highMemLimit, cfgBase;
  logic [2*NS-1:0] shadowAttr;
  logic [NP-1:0] portMemEn;
  logic [32*NP-1:0] portMemBase, portMemLimit, portPfBaseLo, portPfLimitLo;
  logic [HW*NP-1:0] portPfBaseHi, portPfLimitHi;
  logic destValid;
  logic [DW-1:0] destOh;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  addr_router dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqIsIntr(reqIsIntr),
    .topLowMem(topLowMem), .highMemLimit(highMemLimit), .cfgBase(cfgBase),
    .shadowAttr(shadowAttr), .portMemEn(portMemEn),
    .portMemBase(portMemBase), .portMemLimit(portMemLimit),
    .portPfBaseLo(portPfBaseLo), .portPfBaseHi(portPfBaseHi),
    .portPfLimitLo(portPfLimitLo), .portPfLimitHi(portPfLimitHi),
    .destValid(destValid), .destOh(destOh)
  );

  task automatic setMemWin(input int p, input logic [31:0] b, input logic [31:0] l);
    portMemBase[p*32 +: 32]  = b;
    portMemLimit[p*32 +: 32] = l;
  endtask

  task automatic setPfWin(input int p, input logic [AW-1:0] b, input logic [AW-1:0] l);
    portPfBaseLo[p*32 +: 32]  = b[31:0];
    portPfBaseHi[p*HW +: HW]  = b[AW-1:32];
    portPfLimitLo[p*32 +: 32] = l[31:0];
    portPfLimitHi[p*HW +: HW] = l[AW-1:32];
  endtask

  task automatic defaults();
    topLowMem    = 36'h0_8000_0000;
    highMemLimit = 36'h2_0000_0000;
    cfgBase      = 36'h0_E000_0000;
    shadowAttr   = 8'b11_00_01_10; // F=11 E=00 D=01 C=10
    portMemEn    = '1;
    for (int p = 0; p < NP; p++) begin
      setMemWin(p, 32'h9000_0000 + 32'(p) * 32'h0100_0000,
                   32'h90FF_FFFF + 32'(p) * 32'h0100_0000);
      setPfWin(p, 36'h3_0000_0000 + 36'(p) * 36'h1000_0000,
                  36'h3_0FFF_FFFF + 36'(p) * 36'h1000_0000);
    end
  endtask

  // apply one request at a falling edge, read the result one clock later
  task automatic route(input logic [AW-1:0] a, input logic wr, input logic intr,
                       input int expIdx, input string tag);
    logic [DW-1:0] expOh;
    expOh = '0;
    expOh[expIdx] = 1'b1;
    @(negedge clk);
    reqAddr = a; reqWrite = wr; reqIsIntr = intr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if (destValid !== 1'b1 || destOh !== expOh) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b intr=%0b got valid=%0b dest=%b exp valid=1 dest=%b",
               tag, a, wr, intr, destValid, destOh, expOh);
    end
  endtask

  task automatic test_reset();
    checks++;
    if (destValid !== 1'b0 || destOh !== '0) begin
      fails++;
      $display("FAIL R1 reset got valid=%0b dest=%b exp valid=0 dest=0", destValid, destOh);
    end
  endtask

  task automatic test_idle();
    route(36'h0, 1'b0, 1'b0, COH, "R1");
    @(negedge clk);
    checks++;
    if (destValid !== 1'b0 || destOh !== '0) begin
      fails++;
      $display("FAIL R1 idle got valid=%0b dest=%b exp valid=0 dest=0", destValid, destOh);
    end
  endtask

  task automatic test_dos();
    route(36'h0, 1'b1, 1'b0, COH, "R2");
    route(36'h9_FFFF, 1'b0, 1'b0, COH, "R2");
    route(36'h0, 1'b0, 1'b1, COH, "R6 intr outside range");
  endtask

  task automatic test_shadow();
    route(36'hC_0000, 1'b0, 1'b0, LEG,  "R3 C read");
    route(36'hC_0000, 1'b1, 1'b0, NCOH, "R3 C write");
    route(36'hD_FFFF, 1'b0, 1'b0, NCOH, "R3 D read");
    route(36'hD_FFFF, 1'b1, 1'b0, LEG,  "R3 D write");
    route(36'hE_0000, 1'b0, 1'b0, LEG,  "R3 E read");
    route(36'hE_0000, 1'b1, 1'b0, LEG,  "R3 E write");
    route(36'hF_FFFF, 1'b0, 1'b0, NCOH, "R3 F read");
    route(36'hF_FFFF, 1'b1, 1'b0, NCOH, "R3 F write");
  endtask

  task automatic test_lowmem();
    route(36'h10_0000,    1'b0, 1'b0, COH, "R4");
    route(36'h0_7FFF_FFFF, 1'b1, 1'b0, COH, "R4");
  endtask

  task automatic test_cfg();
    route(36'h0_E000_0000, 1'b0, 1'b0, CFG, "R5");
    route(36'h0_EFFF_FFFF, 1'b1, 1'b0, CFG, "R5");
    route(36'h0_F000_0000, 1'b0, 1'b0, ABT, "R5 above region");
    route(36'h0_DFFF_FFFF, 1'b0, 1'b0, ABT, "R5 below region");
    // configuration beats an overlapping port window
    @(negedge clk);
    setMemWin(0, 32'hE000_0000, 32'hE0FF_FFFF);
    route(36'h0_E000_0000, 1'b0, 1'b0, CFG, "R5 priority");
    @(negedge clk);
    setMemWin(0, 32'h9000_0000, 32'h90FF_FFFF);
  endtask

  task automatic test_intr();
    route(36'h0_FEE0_0000, 1'b1, 1'b1, BUS, "R6");
    route(36'h0_FEEF_FFFF, 1'b1, 1'b1, BUS, "R6");
    route(36'h0_FEE0_0000, 1'b0, 1'b0, ABT, "R6 memory type");
  endtask

  task automatic test_fixed_legacy();
    route(36'h0_FEC9_0000, 1'b0, 1'b0, LEG, "R7");
    route(36'h0_FED1_FFFF, 1'b1, 1'b0, LEG, "R7");
    route(36'h0_FF00_0000, 1'b0, 1'b0, LEG, "R7");
    route(36'h0_FFFF_FFFF, 1'b0, 1'b0, LEG, "R7");
  endtask

  task automatic test_highmem();
    route(36'h1_0000_0000, 1'b0, 1'b0, COH, "R8");
    route(36'h1_FFFF_FFFF, 1'b1, 1'b0, COH, "R8");
    route(36'h2_0000_0000, 1'b0, 1'b0, LEG, "R12 above limit");
  endtask

  task automatic test_port_mem();
    route(36'h0_9200_0000, 1'b0, 1'b0, P0 + 2, "R9 base");
    route(36'h0_92FF_FFFF, 1'b1, 1'b0, P0 + 2, "R9 limit");
    route(36'h0_95FF_FFFF, 1'b0, 1'b0, P0 + 5, "R9 port5");
    @(negedge clk);
    setMemWin(4, 32'h9100_0000, 32'h91FF_FFFF);
    route(36'h0_9100_0000, 1'b0, 1'b0, P0 + 1, "R9 lowest port");
    @(negedge clk);
    setMemWin(4, 32'h9400_0000, 32'h94FF_FFFF);
    portMemEn[2] = 1'b0;
    route(36'h0_9200_0000, 1'b0, 1'b0, ABT, "R9 disabled");
    @(negedge clk);
    portMemEn[2] = 1'b1;
  endtask

  task automatic test_gap();
    route(36'h0_8000_0000, 1'b0, 1'b0, ABT, "R10 at top of low memory");
    route(36'h0_9600_0000, 1'b1, 1'b0, ABT, "R10 between windows");
    route(36'h0_FDFF_FFFF, 1'b0, 1'b0, ABT, "R10 end of gap");
  endtask

  task automatic test_prefetch();
    route(36'h3_0000_0000, 1'b0, 1'b0, P0 + 0, "R11 base");
    route(36'h3_0FFF_FFFF, 1'b1, 1'b0, P0 + 0, "R11 limit");
    route(36'h3_5000_0000, 1'b0, 1'b0, P0 + 5, "R11 port5");
    route(36'h3_6000_0000, 1'b0, 1'b0, LEG, "R12 past windows");
    @(negedge clk);
    portMemEn[5] = 1'b0;
    route(36'h3_5000_0000, 1'b0, 1'b0, LEG, "R11 disabled");
    @(negedge clk);
    portMemEn[5] = 1'b1;
  endtask

  task automatic test_subtractive();
    route(36'hA_0000, 1'b0, 1'b0, LEG, "R12");
    route(36'hB_FFFF, 1'b1, 1'b0, LEG, "R12");
    route(36'h0_FE00_0000, 1'b0, 1'b0, LEG, "R12");
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog got no completion exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle();
    test_dos();
    test_shadow();
    test_lowmem();
    test_cfg();
    test_intr();
    test_fixed_legacy();
    test_highmem();
    test_port_mem();
    test_gap();
    test_prefetch();
    test_subtractive();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule